// File: doc/BRIEF.md
# Device Error Signaling Gate

This block takes one detected error at a time and decides what it does to the device's error state. For each accepted error it raises strobes for the device-level detected flags (correctable, non-fatal, fatal, unsupported request) and for the bits to be set in the correctable and uncorrectable status registers. It also asks an external logger to record the error, and decides whether an error message of a given severity goes upstream. The register values that shape the decision arrive as plain inputs: the reporting enables, the system-error enable, the two mask registers and the severity register. The status and log storage they control live outside the block.

An error arrives as a one-hot status vector plus three flags: correctable, possible advisory, and unsupported request. The block accepts it over a valid/ready handshake and presents its decision one cycle later as single-cycle strobes. A non-fatal uncorrectable error flagged as a possible advisory takes the correctable advisory path. If the logger answers a record request with an overflow while a message is being sent, the block stalls its input for one cycle. It then signals a correctable header-log-overflow error of its own.

Top module: `err_signal_gate`

## Requirements
- R1: After reset every output strobe is low, `msg_valid` is low and `in_ready` is high.
- R2: An accepted correctable error with a one-hot status produces, one cycle later, `det_cor` high and `cor_set` equal to the status. `det_ur` follows the unsupported-request flag on every accepted one-hot error.
- R3: A correctable error whose status bit is set in `cor_mask` still sets its status bit but sends no message.
- R4: An unmasked correctable error sends a message (`msg_sev` = 0) only when `en_cor` is high. When the unsupported-request flag is set it also needs `en_ur`.
- R5: A non-fatal uncorrectable error (severity bit clear) with the advisory flag is handled as correctable: `det_cor`, and `cor_set` has only bit `ADV_BIT` set. If `cor_mask[ADV_BIT]` is clear, `unc_set` carries the status, `log_req` is high only when the status bit is clear in `unc_mask`, and the message follows R4. If `cor_mask[ADV_BIT]` is set, nothing else happens.
- R6: A non-advisory uncorrectable error raises `det_fatal` when its bit in `unc_sev` is set, otherwise `det_nonfatal`. A fatal error ignores the advisory flag.
- R7: An uncorrectable error masked in `unc_mask` sets its `unc_set` bit with no `log_req` and no message.
- R8: An unmasked uncorrectable error raises `log_req` in the same cycle as its `unc_set` strobe, so the logger sees the status before the bit is set.
- R9: A fatal message (`msg_sev` = 2) needs `en_serr` or `en_fatal`. A non-fatal message (`msg_sev` = 1) needs `en_serr` or `en_nonfatal`.
- R10: An uncorrectable unsupported request with both `en_ur` and `en_serr` low sends no message.
- R11: When `log_req`, `msg_valid` and `log_overflow` are high together, `in_ready` is low in that cycle. The next cycle shows a correctable error on bit `HLO_BIT`, gated per R3 and R4 with no unsupported request. An overflow with no message causes nothing.
- R12: An accepted status that is zero or has more than one bit set produces no output.
- R13: Outputs are single-cycle and appear only in the cycle after an accepted error or a header-log-overflow event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Error present |
| in_ready | output | 1 | Error accepted this cycle when high with in_valid |
| in_status | input | ERR_W | One-hot error status bit |
| in_is_cor | input | 1 | Error is correctable |
| in_maybe_adv | input | 1 | Error may be treated as advisory non-fatal |
| in_is_ur | input | 1 | Error is an unsupported request |
| en_cor | input | 1 | Correctable reporting enable |
| en_nonfatal | input | 1 | Non-fatal reporting enable |
| en_fatal | input | 1 | Fatal reporting enable |
| en_ur | input | 1 | Unsupported-request reporting enable |
| en_serr | input | 1 | System-error enable |
| cor_mask | input | ERR_W | Correctable mask register |
| unc_mask | input | ERR_W | Uncorrectable mask register |
| unc_sev | input | ERR_W | Uncorrectable severity register, 1 = fatal |
| log_overflow | input | 1 | Logger reports no room for the requested record |
| det_cor | output | 1 | Set correctable-detected |
| det_nonfatal | output | 1 | Set non-fatal-detected |
| det_fatal | output | 1 | Set fatal-detected |
| det_ur | output | 1 | Set unsupported-request-detected |
| cor_set | output | ERR_W | Bits to set in correctable status |
| unc_set | output | ERR_W | Bits to set in uncorrectable status |
| log_req | output | 1 | Record the error in the log |
| msg_valid | output | 1 | Send an error message upstream |
| msg_sev | output | 2 | Message severity: 0 correctable, 1 non-fatal, 2 fatal |

## Verification
The bound checker watches, on every cycle, the properties that never depend on register contents. A message or detect strobe only follows an accepted event. Detect flags are mutually exclusive, and the severity code stays legal. A log request comes with exactly one uncorrectable status bit. An overflow with a message stalls the input and is followed by the header-log-overflow strobe. Whether the right message is chosen for a given mix of masks, severity and enables is something only the bench's sweep can show. The sweep covers every status bit, error kind, mask, severity and enable combination, along with the masked advisory path, unsupported-request gating and the overflow-without-message case.

// File: rtl/esg_pkg.sv
package esg_pkg;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2
  } esg_sev_e;

  typedef enum logic [1:0] {
    PATH_DROP = 2'd0,
    PATH_COR  = 2'd1,
    PATH_ADV  = 2'd2,
    PATH_UNC  = 2'd3
  } esg_path_e;

  // Correctable-class message permission.
  function automatic logic cor_msg_ok(input logic masked, input logic ur,
                                      input logic cor_en, input logic ur_en);
    return !masked && cor_en && (!ur || ur_en);
  endfunction

  // Uncorrectable-class message permission.
  function automatic logic unc_msg_ok(input logic masked, input logic fatal,
                                      input logic ur, input logic serr,
                                      input logic nf_en, input logic f_en,
                                      input logic ur_en);
    if (masked) return 1'b0;
    if (ur && !ur_en && !serr) return 1'b0;
    return serr || (fatal ? f_en : nf_en);
  endfunction

endpackage

// File: rtl/esg_classify.sv
module esg_classify
  import esg_pkg::*;
#(
  parameter int W       = 16,
  parameter int ADV_BIT = 13
) (
  input  logic [W-1:0] status,
  input  logic         is_cor,
  input  logic         maybe_adv,
  input  logic [W-1:0] cor_mask,
  input  logic [W-1:0] unc_mask,
  input  logic [W-1:0] unc_sev,
  output esg_path_e    path,
  output logic         fatal,
  output logic         cor_masked,
  output logic         unc_masked,
  output logic [W-1:0] cor_bits,
  output logic [W-1:0] unc_bits,
  output logic         log_want
);
  localparam logic [W-1:0] ADV_ONEHOT = W'(1) << ADV_BIT;

  logic one_hot;

  assign one_hot    = (status != '0) && ((status & (status - W'(1))) == '0);
  assign fatal      = |(status & unc_sev);
  assign unc_masked = |(status & unc_mask);

  always_comb begin
    if (!one_hot)                path = PATH_DROP;
    else if (is_cor)             path = PATH_COR;
    else if (!fatal && maybe_adv) path = PATH_ADV;
    else                         path = PATH_UNC;
  end

  always_comb begin
    cor_bits   = '0;
    unc_bits   = '0;
    cor_masked = 1'b0;
    log_want   = 1'b0;
    unique case (path)
      PATH_COR: begin
        cor_bits   = status;
        cor_masked = |(status & cor_mask);
      end
      PATH_ADV: begin
        cor_bits   = ADV_ONEHOT;
        cor_masked = cor_mask[ADV_BIT];
        unc_bits   = cor_masked ? '0 : status;
        log_want   = !cor_masked && !unc_masked;
      end
      PATH_UNC: begin
        unc_bits = status;
        log_want = !unc_masked;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/esg_msg_gate.sv
module esg_msg_gate
  import esg_pkg::*;
(
  input  esg_path_e path,
  input  logic      fatal,
  input  logic      cor_masked,
  input  logic      unc_masked,
  input  logic      is_ur,
  input  logic      en_cor,
  input  logic      en_nonfatal,
  input  logic      en_fatal,
  input  logic      en_ur,
  input  logic      en_serr,
  output logic      send,
  output esg_sev_e  sev
);
  always_comb begin
    send = 1'b0;
    sev  = SEV_COR;
    unique case (path)
      PATH_COR, PATH_ADV: begin
        send = cor_msg_ok(cor_masked, is_ur, en_cor, en_ur);
        sev  = SEV_COR;
      end
      PATH_UNC: begin
        send = unc_msg_ok(unc_masked, fatal, is_ur, en_serr,
                          en_nonfatal, en_fatal, en_ur);
        sev  = fatal ? SEV_FATAL : SEV_NONFATAL;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/err_signal_gate.sv
module err_signal_gate
  import esg_pkg::*;
#(
  parameter int ERR_W   = 16,
  parameter int ADV_BIT = 13,
  parameter int HLO_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ERR_W-1:0] in_status,
  input  logic             in_is_cor,
  input  logic             in_maybe_adv,
  input  logic             in_is_ur,
  input  logic             en_cor,
  input  logic             en_nonfatal,
  input  logic             en_fatal,
  input  logic             en_ur,
  input  logic             en_serr,
  input  logic [ERR_W-1:0] cor_mask,
  input  logic [ERR_W-1:0] unc_mask,
  input  logic [ERR_W-1:0] unc_sev,
  input  logic             log_overflow,
  output logic             det_cor,
  output logic             det_nonfatal,
  output logic             det_fatal,
  output logic             det_ur,
  output logic [ERR_W-1:0] cor_set,
  output logic [ERR_W-1:0] unc_set,
  output logic             log_req,
  output logic             msg_valid,
  output logic [1:0]       msg_sev
);
  localparam logic [ERR_W-1:0] HLO_ONEHOT = ERR_W'(1) << HLO_BIT;

  // Named internal events for the checker.
  logic ovf_now;   // logger overflowed while a message went out
  logic take;      // an event is processed this cycle

  logic [ERR_W-1:0] s_status;
  logic             s_is_cor, s_adv, s_ur;

  esg_path_e        path;
  logic             fatal, cor_masked, unc_masked, log_want, send;
  logic [ERR_W-1:0] cor_bits, unc_bits;
  esg_sev_e         sev;

  assign ovf_now  = log_req && msg_valid && log_overflow;
  assign in_ready = !ovf_now;
  assign take     = rst_n && (ovf_now || in_valid);

  // Source select: the overflow event wins over the input.
  assign s_status = ovf_now ? HLO_ONEHOT : in_status;
  assign s_is_cor = ovf_now || in_is_cor;
  assign s_adv    = !ovf_now && in_maybe_adv;
  assign s_ur     = !ovf_now && in_is_ur;

  esg_classify #(.W(ERR_W), .ADV_BIT(ADV_BIT)) u_cls (
    .status    (s_status),
    .is_cor    (s_is_cor),
    .maybe_adv (s_adv),
    .cor_mask  (cor_mask),
    .unc_mask  (unc_mask),
    .unc_sev   (unc_sev),
    .path      (path),
    .fatal     (fatal),
    .cor_masked(cor_masked),
    .unc_masked(unc_masked),
    .cor_bits  (cor_bits),
    .unc_bits  (unc_bits),
    .log_want  (log_want)
  );

  esg_msg_gate u_gate (
    .path       (path),
    .fatal      (fatal),
    .cor_masked (cor_masked),
    .unc_masked (unc_masked),
    .is_ur      (s_ur),
    .en_cor     (en_cor),
    .en_nonfatal(en_nonfatal),
    .en_fatal   (en_fatal),
    .en_ur      (en_ur),
    .en_serr    (en_serr),
    .send       (send),
    .sev        (sev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !take) begin
      det_cor      <= 1'b0;
      det_nonfatal <= 1'b0;
      det_fatal    <= 1'b0;
      det_ur       <= 1'b0;
      cor_set      <= '0;
      unc_set      <= '0;
      log_req      <= 1'b0;
      msg_valid    <= 1'b0;
      msg_sev      <= 2'd0;
    end else begin
      det_cor      <= (path == PATH_COR) || (path == PATH_ADV);
      det_nonfatal <= (path == PATH_UNC) && !fatal;
      det_fatal    <= (path == PATH_UNC) && fatal;
      det_ur       <= (path != PATH_DROP) && s_ur;
      cor_set      <= cor_bits;
      unc_set      <= unc_bits;
      log_req      <= log_want;
      msg_valid    <= send;
      msg_sev      <= send ? 2'(sev) : 2'd0;
    end
  end

endmodule

// File: rtl/esg_checker.sv
module esg_checker #(
  parameter int W       = 16,
  parameter int HLO_BIT = 15
) (
  input logic         clk,
  input logic         rst_n,
  input logic         take,
  input logic         in_ready,
  input logic         log_overflow,
  input logic         det_cor,
  input logic         det_nonfatal,
  input logic         det_fatal,
  input logic         det_ur,
  input logic [W-1:0] cor_set,
  input logic [W-1:0] unc_set,
  input logic         log_req,
  input logic         msg_valid,
  input logic [1:0]   msg_sev
);
  AST_IDLE_RESET: assert property (@(posedge clk)
    $past(!rst_n) |-> in_ready); // R1

  AST_COR_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cor_set) <= 1); // R2

  AST_COR_MSG_HAS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd0) |-> det_cor); // R4

  AST_DETECT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({det_cor, det_nonfatal, det_fatal})); // R6

  AST_SEV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_sev != 2'd3)); // R9

  AST_LOG_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> ($countones(unc_set) == 1)); // R8

  AST_OVF_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (log_req && msg_valid && log_overflow) |-> !in_ready); // R11

  AST_OVF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (log_req && msg_valid && log_overflow) |=> (det_cor && cor_set[HLO_BIT] && !det_ur)); // R11

  AST_OUT_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(take) |-> !(msg_valid || det_cor || det_fatal || det_nonfatal || det_ur || log_req)); // R13
endmodule

bind err_signal_gate esg_checker #(.W(ERR_W), .HLO_BIT(HLO_BIT)) u_esg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .take        (take),
  .in_ready    (in_ready),
  .log_overflow(log_overflow),
  .det_cor     (det_cor),
  .det_nonfatal(det_nonfatal),
  .det_fatal   (det_fatal),
  .det_ur      (det_ur),
  .cor_set     (cor_set),
  .unc_set     (unc_set),
  .log_req     (log_req),
  .msg_valid   (msg_valid),
  .msg_sev     (msg_sev)
);

// File: tb/err_signal_gate_test.sv
module err_signal_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int ADV = 5;
  localparam int HLO = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_status = '0;
  logic in_is_cor = 1'b0, in_maybe_adv = 1'b0, in_is_ur = 1'b0;
  logic en_cor = 1'b0, en_nonfatal = 1'b0, en_fatal = 1'b0, en_ur = 1'b0, en_serr = 1'b0;
  logic [W-1:0] cor_mask = '0, unc_mask = '0, unc_sev = '0;
  logic log_overflow = 1'b0;
  logic det_cor, det_nonfatal, det_fatal, det_ur;
  logic [W-1:0] cor_set, unc_set;
  logic log_req, msg_valid;
  logic [1:0] msg_sev;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_signal_gate #(.ERR_W(W), .ADV_BIT(ADV), .HLO_BIT(HLO)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_status(in_status), .in_is_cor(in_is_cor), .in_maybe_adv(in_maybe_adv),
    .in_is_ur(in_is_ur), .en_cor(en_cor), .en_nonfatal(en_nonfatal),
    .en_fatal(en_fatal), .en_ur(en_ur), .en_serr(en_serr),
    .cor_mask(cor_mask), .unc_mask(unc_mask), .unc_sev(unc_sev),
    .log_overflow(log_overflow), .det_cor(det_cor), .det_nonfatal(det_nonfatal),
    .det_fatal(det_fatal), .det_ur(det_ur), .cor_set(cor_set), .unc_set(unc_set),
    .log_req(log_req), .msg_valid(msg_valid), .msg_sev(msg_sev)
  );

  // Expected values
  logic e_dc, e_dnf, e_df, e_dur, e_log, e_msg;
  logic [W-1:0] e_cs, e_us;
  logic [1:0] e_sev;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] det_vec();
    return {28'd0, det_cor, det_nonfatal, det_fatal, det_ur};
  endfunction

  task automatic model(input logic [W-1:0] st, input bit c, input bit a, input bit u,
                       input logic [4:0] en);
    bit fat;
    {e_dc, e_dnf, e_df, e_dur, e_log, e_msg} = '0;
    e_cs = '0; e_us = '0; e_sev = 2'd0;
    if (st == '0 || $countones(st) != 1) return;
    e_dur = u;
    if (c) begin
      e_dc = 1; e_cs = st;
      if ((st & cor_mask) == '0 && en[0] && (!u || en[3])) e_msg = 1;
    end else begin
      fat = (st & unc_sev) != '0;
      if (!fat && a) begin
        e_dc = 1; e_cs = W'(1) << ADV;
        if (!cor_mask[ADV]) begin
          e_us = st;
          e_log = (st & unc_mask) == '0;
          if (en[0] && (!u || en[3])) e_msg = 1;
        end
      end else begin
        e_df = fat; e_dnf = !fat; e_us = st;
        if ((st & unc_mask) == '0) begin
          e_log = 1;
          if (!(u && !en[3] && !en[4]) && (en[4] || (fat ? en[2] : en[1]))) begin
            e_msg = 1; e_sev = fat ? 2'd2 : 2'd1;
          end
        end
      end
    end
  endtask

  task automatic compare(input string pfx);
    chk(det_vec() == {28'd0, e_dc, e_dnf, e_df, e_dur}, "R2 R5 R6",
        {pfx, " detect"}, det_vec(), {28'd0, e_dc, e_dnf, e_df, e_dur});
    chk(cor_set == e_cs && unc_set == e_us, "R3 R5 R7",
        {pfx, " status"}, {16'd0, cor_set, unc_set}, {16'd0, e_cs, e_us});
    chk(log_req == e_log, "R5 R7 R8", {pfx, " log"}, 32'(log_req), 32'(e_log));
    chk(msg_valid == e_msg && (!e_msg || msg_sev == e_sev), "R3 R4 R9 R10",
        {pfx, " message"}, {29'd0, msg_valid, msg_sev}, {29'd0, e_msg, e_sev});
  endtask

  task automatic quiet(input string tag);
    logic [31:0] act;
    act = {det_vec()[3:0], log_req, msg_valid, 2'd0, cor_set, unc_set, 8'd0};
    chk(act == '0, tag, "idle outputs", act, 32'd0);
  endtask

  task automatic run_event(input logic [W-1:0] st, input bit c, input bit a,
                           input bit u, input logic [4:0] en, input bit ovf);
    bit exp_ovf;
    {en_serr, en_ur, en_fatal, en_nonfatal, en_cor} = en;
    in_status = st; in_is_cor = c; in_maybe_adv = a; in_is_ur = u;
    log_overflow = ovf; in_valid = 1'b1;
    model(st, c, a, u, en);
    exp_ovf = e_log && e_msg && ovf;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    compare("event");
    chk(in_ready == !exp_ovf, "R11", "in_ready", 32'(in_ready), 32'(!exp_ovf));
    @(posedge clk); @(negedge clk);
    if (exp_ovf) begin
      model(W'(1) << HLO, 1'b1, 1'b0, 1'b0, en);
      compare("R11 overflow event");
    end else begin
      quiet("R13 R11");
    end
    log_overflow = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    quiet("R1");
    chk(in_ready == 1'b1, "R1", "in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    quiet("R1");

    // R12: zero and multi-bit status
    for (int v = 0; v < 4; v++) begin
      logic [W-1:0] bad;
      bad = (v == 0) ? '0 : (v == 1) ? 8'h03 : (v == 2) ? 8'h81 : 8'hFF;
      run_event(bad, v[0], 1'b0, 1'b1, 5'h1F, 1'b0);
      quiet("R12");
    end

    // Near-exhaustive sweep
    for (int b = 0; b < W; b++)
      for (int k = 0; k < 64; k++)
        for (int en = 0; en < 32; en++) begin
          cor_mask = k[3] ? 8'hFF : 8'h00;
          unc_mask = k[4] ? 8'hFF : 8'h00;
          unc_sev  = k[5] ? 8'hFF : 8'h00;
          run_event(W'(1) << b, k[0], k[1], k[2], 5'(en),
                    en[0] ^ k[3] ^ en[4]);
        end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule